// File: doc/BRIEF.md
# Auto-Incrementing Work-Memory Data Port

This block gives a processor a narrow, register-mapped view into a large work memory. Software sets up a 17-bit pointer by writing up to three byte-wide pointer registers: low byte, middle byte, and a top register of which only bit 0 is kept. It then streams bytes through a single data register. Every access to the data register, read or write, uses the location the pointer names and then advances the pointer by one. The pointer wraps from the top of its 17-bit range back to zero.

The host side is a 16-bit register address, an 8-bit write bus, separate read and write strobes, and an open-bus byte input. Reads of registers the block does not return are answered with the open-bus byte. The pointer is also presented as a 24-bit system address, with the window placed at the fixed base 0x7E0000.

The memory is a synchronous single-port byte RAM. Its depth is set by `RAM_AW`. The default of 12 gives 4 KiB, which keeps elaboration small. The full 17-bit pointer is still kept and shown, and pointer bits at or above `RAM_AW` alias.

A controller with three states sequences each access:

- `ST_IDLE` accepts a strobe. If the write strobe is high it performs a write, whether or not the read strobe is also high, and goes to `ST_HOLD`. A read strobe alone starts a read and goes to `ST_RESP`.
- `ST_RESP` presents the read response for one cycle. It then goes to `ST_HOLD` if a strobe is still high, otherwise back to `ST_IDLE`.
- `ST_HOLD` waits until both strobes are low, then returns to `ST_IDLE`.

Top module: `wram_port`

## Requirements
- R1: After reset, `ptr_addr` is 0x7E0000 (pointer zero) and `rd_valid` is low.
- R2: A write to 0x2181 loads pointer bits 7..0 from `wr_data`, and a write to 0x2182 loads pointer bits 15..8. All other pointer bits are unchanged.
- R3: A write to 0x2183 loads pointer bit 16 from `wr_data` bit 0. Data bits 7..1 are ignored, and pointer bits 15..0 are unchanged.
- R4: `ptr_addr` always equals 0x7E0000 plus the 17-bit pointer.
- R5: A write to 0x2180 stores `wr_data` at the current pointer, then increments the pointer by one.
- R6: A read of 0x2180 returns the byte at the current pointer and increments the pointer by one. `rd_valid` is high for exactly the one cycle after the accepting clock edge, and `rd_data` carries the byte in that cycle.
- R7: Incrementing the pointer from 0x1FFFF gives 0x00000.
- R8: A strobe held high for several cycles causes exactly one access. A new access is accepted only after both strobes have been low at a clock edge.
- R9: A read of any address other than 0x2180, including 0x2181 to 0x2183, returns the `open_bus` value sampled at the accepting edge, with the same one-cycle timing as R6. The pointer is unchanged.
- R10: A write to any address other than 0x2180 to 0x2183 leaves the pointer and the memory unchanged.
- R11: When both strobes rise in the same cycle, only the write is performed and no read response is given.
- R12: The memory holds 2^`RAM_AW` bytes indexed by the low `RAM_AW` pointer bits. Pointers that differ only in higher bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Register address of the access |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Read strobe, may be held |
| wr_stb | input | 1 | Write strobe, may be held |
| open_bus | input | 8 | Byte returned for reads the block does not serve |
| rd_data | output | 8 | Read response byte, valid while `rd_valid` |
| rd_valid | output | 1 | One-cycle read response flag |
| ptr_addr | output | 24 | System address the pointer selects |

## Verification
The hardest situations to reach are those where strobe timing, not the register address, decides the result. One is a strobe held across many edges, which must still give one pointer step. Another is both strobes rising together, where the write must win and no response may appear. The bench reaches these with directed sequences that hold a strobe for several cycles, or raise both in the same cycle. It then reloads the pointer and reads back to see how many bytes were written and where. Wrap and aliasing are reached by loading the pointer with its top value, or with bit 16 set, before accessing the data register.

// File: rtl/wram_port_pkg.sv
package wram_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_HOLD = 2'd2
    } port_state_e;

    localparam logic [15:0] REG_DATA    = 16'h2180;
    localparam logic [15:0] REG_PTR_BASE = 16'h2181;
    localparam logic [23:0] WINDOW_BASE = 24'h7E0000;

endpackage

// File: rtl/wram_ptr.sv
module wram_ptr #(
    parameter int PTR_W = 17,
    localparam int LANES = (PTR_W + 7) / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] ld,
    input  logic             inc,
    input  logic [7:0]       din,
    output logic [PTR_W-1:0] ptr
);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ld_mask;
    logic [PTR_W-1:0] ld_val;
    logic [PTR_W-1:0] ptr_nxt;

    // each byte lane gets its own load mask; the top lane may be narrower
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int LO = 8 * l;
        localparam int LW = (l == LANES - 1) ? (PTR_W - 8 * l) : 8;
        assign ld_mask[LO +: LW] = {LW{ld[l]}};
        assign ld_val[LO +: LW]  = din[LW-1:0];
    end

    always_comb begin
        ptr_nxt = ptr_q;
        if (|ld) begin
            ptr_nxt = (ptr_q & ~ld_mask) | (ld_val & ld_mask);
        end else if (inc) begin
            ptr_nxt = ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_nxt;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/wram_ram.sv
module wram_ram #(
    parameter int AW = 12,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    q
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            q <= mem[addr];
        end
    end

endmodule

// File: rtl/wram_ctrl.sv
module wram_ctrl
    import wram_port_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             hit_data,
    input  logic [LANES-1:0] hit_ptr,
    output logic             rd_acc,
    output logic             wr_acc,
    output logic             ram_we,
    output logic             ram_re,
    output logic [LANES-1:0] ptr_ld,
    output logic             ptr_inc,
    output logic             rsp_valid
);

    port_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_stb) begin
                    state_d = ST_HOLD;
                end else if (rd_stb) begin
                    state_d = ST_RESP;
                end
            end
            ST_RESP: begin
                state_d = (rd_stb || wr_stb) ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (!rd_stb && !wr_stb) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_acc    = 1'b0;
        wr_acc    = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_acc = wr_stb;
                rd_acc = rd_stb && !wr_stb;
            end
            ST_RESP: rsp_valid = 1'b1;
            ST_HOLD: ;
            default: ;
        endcase
        ram_we  = wr_acc && hit_data;
        ram_re  = rd_acc && hit_data;
        ptr_inc = (wr_acc || rd_acc) && hit_data;
        ptr_ld  = wr_acc ? hit_ptr : '0;
    end

endmodule

// File: rtl/wram_port.sv
module wram_port
    import wram_port_pkg::*;
#(
    parameter int PTR_W  = 17,
    parameter int RAM_AW = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] reg_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_stb,
    input  logic        wr_stb,
    input  logic [7:0]  open_bus,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic [23:0] ptr_addr
);

    localparam int LANES = (PTR_W + 7) / 8;

    logic             hit_data;
    logic [LANES-1:0] hit_ptr;
    logic             rd_acc, wr_acc;
    logic             ram_we, ram_re, ptr_inc, rsp_valid;
    logic [LANES-1:0] ptr_ld;
    logic [PTR_W-1:0] ptr_q;
    logic [7:0]       ram_q;
    logic             src_ram_q;
    logic [7:0]       ob_q;
    logic             ptr_touch;

    assign hit_data = (reg_addr == REG_DATA);
    for (genvar i = 0; i < LANES; i++) begin : g_dec
        assign hit_ptr[i] = (reg_addr == REG_PTR_BASE + 16'(i));
    end

    wram_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .hit_data  (hit_data),
        .hit_ptr   (hit_ptr),
        .rd_acc    (rd_acc),
        .wr_acc    (wr_acc),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ptr_ld    (ptr_ld),
        .ptr_inc   (ptr_inc),
        .rsp_valid (rsp_valid)
    );

    wram_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ptr_ld),
        .inc   (ptr_inc),
        .din   (wr_data),
        .ptr   (ptr_q)
    );

    wram_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ptr_q[RAM_AW-1:0]),
        .wdata (wr_data),
        .q     (ram_q)
    );

    // response source captured at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ram_q <= 1'b0;
            ob_q      <= '0;
        end else if (rd_acc) begin
            src_ram_q <= hit_data;
            ob_q      <= open_bus;
        end
    end

    assign ptr_touch = ptr_inc || (|ptr_ld);
    assign rd_valid  = rsp_valid;
    assign rd_data   = rsp_valid ? (src_ram_q ? ram_q : ob_q) : 8'h00;
    assign ptr_addr  = WINDOW_BASE + 24'(ptr_q);

endmodule

// File: rtl/wram_port_chk.sv
module wram_port_chk #(
    parameter int PTR_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_acc,
    input logic             wr_acc,
    input logic             ptr_inc,
    input logic             ptr_touch,
    input logic [PTR_W-1:0] ptr,
    input logic             rd_valid
);

    localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    // R5 R6 R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_inc |=> (ptr == $past(ptr) + ONE));

    // R10
    ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_touch |=> $stable(ptr));

    // R6
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_valid);

    // R6
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc || wr_acc) |=> !(rd_acc || wr_acc));

    // R11
    wr_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !rd_valid);

endmodule

bind wram_port wram_port_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_acc    (rd_acc),
    .wr_acc    (wr_acc),
    .ptr_inc   (ptr_inc),
    .ptr_touch (ptr_touch),
    .ptr       (ptr_q),
    .rd_valid  (rd_valid)
);

// File: tb/tb_wram_port.sv
module tb_wram_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  open_bus = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [23:0] ptr_addr;

    int vec_cnt = 0;
    int fail_cnt = 0;

    always #5 clk = ~clk;

    wram_port dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .open_bus (open_bus),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .ptr_addr (ptr_addr)
    );

    // vector: {op[1:0], addr[15:0], data[7:0], exp[7:0]}
    // op 0 = write, 1 = read (data field drives open_bus), 2 = check ptr low byte
    localparam int NV = 18;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 16'h2181, 8'h10, 8'h00},  // R2
        {2'd0, 16'h2182, 8'h02, 8'h00},  // R2
        {2'd0, 16'h2183, 8'hFE, 8'h00},  // R3: bit0=0, rest ignored
        {2'd0, 16'h2180, 8'hAA, 8'h00},  // R5
        {2'd0, 16'h2180, 8'hBB, 8'h00},  // R5
        {2'd0, 16'h2180, 8'hCC, 8'h00},  // R5
        {2'd2, 16'h0000, 8'h00, 8'h13},  // R5 pointer advanced three
        {2'd0, 16'h2181, 8'h10, 8'h00},  // R2
        {2'd1, 16'h2180, 8'h00, 8'hAA},  // R6
        {2'd1, 16'h2180, 8'h00, 8'hBB},  // R6
        {2'd1, 16'h2181, 8'h5A, 8'h5A},  // R9
        {2'd2, 16'h0000, 8'h00, 8'h12},  // R9 pointer unchanged
        {2'd1, 16'h2180, 8'h00, 8'hCC},  // R6
        {2'd0, 16'h2183, 8'h01, 8'h00},  // R3
        {2'd0, 16'h2181, 8'h10, 8'h00},  // R2
        {2'd1, 16'h2180, 8'h00, 8'hAA},  // R12 alias of 0x00210
        {2'd1, 16'h2183, 8'hC3, 8'hC3},  // R9
        {2'd2, 16'h0000, 8'h00, 8'h11}   // R9
    };

    task automatic check(input bit ok, input string req, input logic [23:0] act,
                         input logic [23:0] exp);
        vec_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        reg_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_rd(input logic [15:0] a, input logic [7:0] ob,
                         output logic [7:0] d, output logic v);
        reg_addr = a; open_bus = ob; rd_stb = 1'b1;
        @(negedge clk);
        d = rd_data; v = rd_valid;
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_ptr(input logic [16:0] p);
        do_wr(16'h2181, p[7:0]);
        do_wr(16'h2182, p[15:8]);
        do_wr(16'h2183, {7'b0, p[16]});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        vec_cnt++; fail_cnt++;
        $display("FAIL watchdog actual=%h expected=%h", 24'h1, 24'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       v;
        int         nv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ptr_addr == 24'h7E0000, "R1 ptr_addr", ptr_addr, 24'h7E0000);
        check(rd_valid == 1'b0, "R1 rd_valid", 24'(rd_valid), 24'h0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [15:0] a;
            logic [7:0]  dd, ex;
            {op, a, dd, ex} = VEC[i];
            if (op == 2'd0) begin
                do_wr(a, dd);
            end else if (op == 2'd1) begin
                do_rd(a, dd, d, v);
                check(v == 1'b1, "R6/R9 rd_valid", 24'(v), 24'h1);
                check(d == ex, "R6/R9/R12 rd_data", 24'(d), 24'(ex));
            end else begin
                check(ptr_addr[7:0] == ex, "R2/R5/R9 ptr low", 24'(ptr_addr[7:0]), 24'(ex));
            end
        end
        check(ptr_addr == 24'h7F0211, "R4 ptr_addr", ptr_addr, 24'h7F0211);

        // R7 wrap
        load_ptr(17'h1FFFF);
        check(ptr_addr == 24'h7FFFFF, "R4 top ptr_addr", ptr_addr, 24'h7FFFFF);
        do_wr(16'h2180, 8'h77);
        check(ptr_addr == 24'h7E0000, "R7 wrap", ptr_addr, 24'h7E0000);
        load_ptr(17'h1FFFF);
        do_rd(16'h2180, 8'h00, d, v);
        check(d == 8'h77, "R5 wrap readback", 24'(d), 24'h77);

        // R8 held read
        reg_addr = 16'h2180; rd_stb = 1'b1;
        nv = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (rd_valid) nv++;
        end
        rd_stb = 1'b0;
        @(negedge clk);
        check(nv == 1, "R8 held read responses", 24'(nv), 24'h1);
        check(ptr_addr == 24'h7E0001, "R8 held read ptr", ptr_addr, 24'h7E0001);

        // R8 held write
        reg_addr = 16'h2180; wr_data = 8'h42; wr_stb = 1'b1;
        repeat (3) @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
        check(ptr_addr == 24'h7E0002, "R8 held write ptr", ptr_addr, 24'h7E0002);
        do_wr(16'h2181, 8'h01);
        do_rd(16'h2180, 8'h00, d, v);
        check(d == 8'h42, "R8 held write data", 24'(d), 24'h42);

        // R11 both strobes together
        reg_addr = 16'h2180; wr_data = 8'h99; wr_stb = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R11 no response", 24'(rd_valid), 24'h0);
        wr_stb = 1'b0; rd_stb = 1'b0;
        @(negedge clk);
        check(ptr_addr == 24'h7E0003, "R11 single step", ptr_addr, 24'h7E0003);
        do_wr(16'h2181, 8'h02);
        do_rd(16'h2180, 8'h00, d, v);
        check(d == 8'h99, "R11 write done", 24'(d), 24'h99);

        // R10 writes elsewhere ignored
        do_wr(16'h2184, 8'h55);
        do_wr(16'h0180, 8'h66);
        do_wr(16'h2080, 8'h01);
        check(ptr_addr == 24'h7E0003, "R10 ptr unchanged", ptr_addr, 24'h7E0003);
        do_wr(16'h2181, 8'h02);
        do_rd(16'h2180, 8'h00, d, v);
        check(d == 8'h99, "R10 memory unchanged", 24'(d), 24'h99);

        // R1 reset mid-run
        load_ptr(17'h0ABCD);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ptr_addr == 24'h7E0000, "R1 reset clears", ptr_addr, 24'h7E0000);

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
        $finish;
    end

endmodule